// File: doc/BRIEF.md
# Dual Event Counter with Overflow Signal Pin

This block holds a small set of programmable event counters fed by a vector of bus-activity qualifiers. Each counter has its own selection register that chooses one of seven bus events, whether transaction events count only this agent or any agent on the bus, and how an overflow is reported. Each bus clock, a counter adds one when its selected event is active. Transaction events count completed burst, memory or any-kind transactions. Duration events count the clocks during which this agent receives data or drives one of three bus response signals, including snoop-stall clocks.

When a counter wraps from all ones to zero, the block reports the overflow on that counter's monitor pin. A per-counter control bit chooses the reporting mode. In pulse mode the pin is high for one clock. In level mode the pin changes level on every overflow. A static clock-ratio input enables the pins. At any core-to-bus ratio other than 2:1 or 3:1 the pins stay low, and the counters keep counting.

Each pin is driven by a three-state machine. `PS_LOW` is the idle state with the pin low. `PS_PULSE` holds the pin high for one clock. `PS_LEVEL` holds the pin high until the next overflow in level mode.
- From `PS_LOW`, an enabled overflow with the control bit set moves to `PS_PULSE`. An enabled overflow with the control bit clear moves to `PS_LEVEL`.
- `PS_PULSE` always returns to `PS_LOW` after one clock.
- From `PS_LEVEL`, an enabled overflow with the control bit clear returns to `PS_LOW`. An enabled overflow with the control bit set moves to `PS_PULSE`.
- While the ratio is unsupported, overflows are not enabled and `PS_LOW` and `PS_LEVEL` hold.

Top module: `evt_ovf_monitor`

## Requirements
- R1: After reset, every counter and every selection register reads zero, and every monitor pin is low.
- R2: Register addresses are formed as {kind, index}: kind 0 is the selection register and kind 1 is the counter of counter `index`. A selection register keeps bits [19:0] as written and reads them back, with upper bits zero. Its fields are event code [7:0], unit mask [15:8] and pin-control bit [19]. A counter takes the low CNT_W bits of a write and reads back zero-extended. Reads are combinational on `rd_addr`.
- R3: `bus_evt` bit positions are as follows:
  - Bits 0, 1 and 2 are this agent's completed burst, memory and any-kind transactions.
  - Bits 3, 4 and 5 are the same transaction kinds completed by other agents.
  - Bit 6 is data receive.
  - Bits 7, 8 and 9 are driving of the bus-not-ready, hit and modified-hit signals.
  
  Transaction codes are 6Eh (burst), 6Fh (memory) and 70h (any-kind). With unit mask 00h a transaction code counts this agent's bit only. With unit mask 20h it counts one per clock in which this agent's bit or the other agents' bit is high.
- R4: Duration codes are 64h (data receive), 61h (bus-not-ready), 7Ah (hit) and 7Bh (modified hit). Each adds one per clock in which its input is high, under unit mask 00h or 20h alike.
- R5: A code outside the seven above, or a unit mask other than 00h or 20h, counts nothing.
- R6: A counter write in the same clock as an increment loads the written value. With no event and no write, a counter holds its value.
- R7: A counter wraps from all ones to zero and keeps counting. Only an increment signals an overflow; a write of any value never does.
- R8: With the pin-control bit set and `clk_ratio` 00 (2:1) or 01 (3:1), the counter's pin is high for exactly the one clock in which the counter first reads zero after the wrap.
- R9: With the pin-control bit clear and a supported ratio, the counter's pin changes level at each overflow and holds that level between overflows.
- R10: With `clk_ratio` 10 or 11 the pins are low and counting continues. Overflows in this time leave the level-mode state unchanged, so the held level reappears when the ratio becomes supported again.
- R11: Each pin reacts only to its own counter's overflows, and each counter only to its own selection register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | ADDR_W | Write address {kind, index} |
| wr_data | input | DATA_W | Write data, DATA_W = max(CNT_W, 20) |
| rd_addr | input | ADDR_W | Read address {kind, index} |
| rd_data | output | DATA_W | Combinational read data |
| bus_evt | input | 10 | Event qualifier inputs |
| clk_ratio | input | 2 | Core-to-bus ratio code: 00 = 2:1, 01 = 3:1, others unsupported |
| ovf_pin | output | NUM_CNT | Per-counter overflow monitor pins |

## Verification
The bench builds the block with two counters of 16 bits. Writing a value just below all ones lets each pulse, level and ratio-gating case start one or two clocks before a wrap. The narrow width also brings a full natural wrap from zero within reach: 65536 data-receive clocks.

With this width, DATA_W becomes 20, so the pin-control bit is the top bit of the write port. The narrow counter also truncates a wide write, which the read-back check observes.

// File: rtl/evtmon_pkg.sv
package evtmon_pkg;

    localparam int EVT_W   = 10;
    localparam int SEL_W   = 20;

    // bus_evt bit positions
    localparam int EB_BURST_SELF  = 0;
    localparam int EB_MEM_SELF    = 1;
    localparam int EB_ALL_SELF    = 2;
    localparam int EB_BURST_OTHER = 3;
    localparam int EB_MEM_OTHER   = 4;
    localparam int EB_ALL_OTHER   = 5;
    localparam int EB_DATA_RCV    = 6;
    localparam int EB_BNR_DRV     = 7;
    localparam int EB_HIT_DRV     = 8;
    localparam int EB_HITM_DRV    = 9;

    // event codes
    localparam logic [7:0] EC_BURST    = 8'h6E;
    localparam logic [7:0] EC_MEM      = 8'h6F;
    localparam logic [7:0] EC_ALL      = 8'h70;
    localparam logic [7:0] EC_DATA_RCV = 8'h64;
    localparam logic [7:0] EC_BNR      = 8'h61;
    localparam logic [7:0] EC_HIT      = 8'h7A;
    localparam logic [7:0] EC_HITM     = 8'h7B;

    localparam logic [7:0] UM_SELF = 8'h00;
    localparam logic [7:0] UM_ANY  = 8'h20;

    localparam logic [1:0] RATIO_2_1 = 2'b00;
    localparam logic [1:0] RATIO_3_1 = 2'b01;

    // selection register layout, pin control at bit 19
    typedef struct packed {
        logic       pin_ctl;
        logic [2:0] rsvd;
        logic [7:0] umask;
        logic [7:0] code;
    } evsel_t;

    typedef enum logic [1:0] {
        PS_LOW   = 2'd0,
        PS_PULSE = 2'd1,
        PS_LEVEL = 2'd2
    } pin_state_e;

endpackage

// File: rtl/evtmon_decode.sv
module evtmon_decode
    import evtmon_pkg::*;
(
    input  logic [7:0]       code,
    input  logic [7:0]       umask,
    input  logic [EVT_W-1:0] bus_evt,
    output logic             hit
);
    logic mask_self;
    logic mask_any;
    logic mask_ok;

    assign mask_self = (umask == UM_SELF);
    assign mask_any  = (umask == UM_ANY);
    assign mask_ok   = mask_self || mask_any;

    always_comb begin
        hit = 1'b0;
        case (code)
            EC_BURST:    hit = (mask_ok  && bus_evt[EB_BURST_SELF])
                            || (mask_any && bus_evt[EB_BURST_OTHER]);
            EC_MEM:      hit = (mask_ok  && bus_evt[EB_MEM_SELF])
                            || (mask_any && bus_evt[EB_MEM_OTHER]);
            EC_ALL:      hit = (mask_ok  && bus_evt[EB_ALL_SELF])
                            || (mask_any && bus_evt[EB_ALL_OTHER]);
            EC_DATA_RCV: hit = mask_ok && bus_evt[EB_DATA_RCV];
            EC_BNR:      hit = mask_ok && bus_evt[EB_BNR_DRV];
            EC_HIT:      hit = mask_ok && bus_evt[EB_HIT_DRV];
            EC_HITM:     hit = mask_ok && bus_evt[EB_HITM_DRV];
            default:     hit = 1'b0;
        endcase
    end

endmodule

// File: rtl/evtmon_counter.sv
module evtmon_counter #(
    parameter int CNT_W = 40
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [CNT_W-1:0] wr_val,
    input  logic             inc,
    output logic [CNT_W-1:0] cnt,
    output logic             ovf
);
    localparam logic [CNT_W-1:0] ALL_ONES = '1;

    assign ovf = inc && !wr_en && (cnt == ALL_ONES);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (wr_en) begin
            cnt <= wr_val;
        end else if (inc) begin
            cnt <= cnt + 1'b1;
        end
    end

    AST_WRITE_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> cnt == $past(wr_val));  // R6
    AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_en && !inc) |=> $stable(cnt));  // R6
    AST_STEP_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        (inc && !wr_en) |=> cnt == $past(cnt) + 1'b1);  // R7

endmodule

// File: rtl/evtmon_pin_fsm.sv
module evtmon_pin_fsm
    import evtmon_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic ovf,
    input  logic pin_ctl,
    input  logic ratio_ok,
    output logic pin
);
    pin_state_e state;
    pin_state_e state_nx;
    logic       ovf_en;

    assign ovf_en = ovf && ratio_ok;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= PS_LOW;
        end else begin
            state <= state_nx;
        end
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            PS_LOW: begin
                if (ovf_en) begin
                    state_nx = pin_ctl ? PS_PULSE : PS_LEVEL;
                end
            end
            PS_PULSE: begin
                state_nx = PS_LOW;
            end
            PS_LEVEL: begin
                if (ovf_en) begin
                    state_nx = pin_ctl ? PS_PULSE : PS_LOW;
                end
            end
            default: state_nx = PS_LOW;
        endcase
    end

    always_comb begin
        pin = 1'b0;
        unique case (state)
            PS_LOW:   pin = 1'b0;
            PS_PULSE: pin = ratio_ok;
            PS_LEVEL: pin = ratio_ok;
            default:  pin = 1'b0;
        endcase
    end

    AST_FROZEN_BAD_RATIO: assert property (@(posedge clk) disable iff (!rst_n)
        (!ratio_ok && state != PS_PULSE) |=> state == $past(state));  // R10
    AST_PULSE_LEAVES: assert property (@(posedge clk) disable iff (!rst_n)
        (state == PS_PULSE) |=> state != PS_PULSE);  // R8

endmodule

// File: rtl/evt_ovf_monitor.sv
module evt_ovf_monitor
    import evtmon_pkg::*;
#(
    parameter  int NUM_CNT = 2,
    parameter  int CNT_W   = 40,
    localparam int IDX_W   = (NUM_CNT > 1) ? $clog2(NUM_CNT) : 1,
    localparam int ADDR_W  = IDX_W + 1,
    localparam int DATA_W  = (CNT_W > SEL_W) ? CNT_W : SEL_W
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_en,
    input  logic [ADDR_W-1:0]  wr_addr,
    input  logic [DATA_W-1:0]  wr_data,
    input  logic [ADDR_W-1:0]  rd_addr,
    output logic [DATA_W-1:0]  rd_data,
    input  logic [EVT_W-1:0]   bus_evt,
    input  logic [1:0]         clk_ratio,
    output logic [NUM_CNT-1:0] ovf_pin
);
    logic             ratio_ok;
    evsel_t           sel   [NUM_CNT];
    logic [CNT_W-1:0] cnt   [NUM_CNT];
    logic [NUM_CNT-1:0] ovf;

    assign ratio_ok = (clk_ratio == RATIO_2_1) || (clk_ratio == RATIO_3_1);

    for (genvar i = 0; i < NUM_CNT; i++) begin : g_cnt
        logic sel_we;
        logic cnt_we;
        logic hit;

        assign sel_we = wr_en && !wr_addr[ADDR_W-1] && (wr_addr[IDX_W-1:0] == IDX_W'(i));
        assign cnt_we = wr_en &&  wr_addr[ADDR_W-1] && (wr_addr[IDX_W-1:0] == IDX_W'(i));

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                sel[i] <= '0;
            end else if (sel_we) begin
                sel[i] <= evsel_t'(wr_data[SEL_W-1:0]);
            end
        end

        evtmon_decode u_dec (
            .code    (sel[i].code),
            .umask   (sel[i].umask),
            .bus_evt (bus_evt),
            .hit     (hit)
        );

        evtmon_counter #(.CNT_W(CNT_W)) u_cnt (
            .clk    (clk),
            .rst_n  (rst_n),
            .wr_en  (cnt_we),
            .wr_val (wr_data[CNT_W-1:0]),
            .inc    (hit),
            .cnt    (cnt[i]),
            .ovf    (ovf[i])
        );

        evtmon_pin_fsm u_pin (
            .clk      (clk),
            .rst_n    (rst_n),
            .ovf      (ovf[i]),
            .pin_ctl  (sel[i].pin_ctl),
            .ratio_ok (ratio_ok),
            .pin      (ovf_pin[i])
        );

        AST_PULSE_AFTER_OVF: assert property (@(posedge clk) disable iff (!rst_n)
            (ovf[i] && ratio_ok && sel[i].pin_ctl) |=> (ovf_pin[i] || !ratio_ok));  // R8
        AST_PULSE_ENDS: assert property (@(posedge clk) disable iff (!rst_n)
            (ovf[i] && ratio_ok && sel[i].pin_ctl) |=> ##1 !ovf_pin[i]);  // R8
        AST_TOGGLE_ON_OVF: assert property (@(posedge clk) disable iff (!rst_n)
            (ovf[i] && ratio_ok && !sel[i].pin_ctl) |=> (!ratio_ok || ovf_pin[i] != $past(ovf_pin[i])));  // R9
        AST_PIN_RISE_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
            ($rose(ovf_pin[i]) && $stable(clk_ratio)) |-> $past(ovf[i]));  // R11
        AST_WRITE_NO_OVF: assert property (@(posedge clk) disable iff (!rst_n)
            cnt_we |-> !ovf[i]);  // R7
    end

    always_comb begin
        rd_data = '0;
        for (int k = 0; k < NUM_CNT; k++) begin
            if (rd_addr[IDX_W-1:0] == IDX_W'(k)) begin
                if (rd_addr[ADDR_W-1]) begin
                    rd_data[CNT_W-1:0] = cnt[k];
                end else begin
                    rd_data[SEL_W-1:0] = sel[k];
                end
            end
        end
    end

    AST_PINS_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !ratio_ok |-> (ovf_pin == '0));  // R10

endmodule

// File: tb/evt_ovf_monitor_tb_top.sv
`timescale 1ns/1ps
module evt_ovf_monitor_tb_top;
    localparam int NC  = 2;
    localparam int CW  = 16;
    localparam int DW  = 20;
    localparam int AW  = 2;

    localparam logic [AW-1:0] A_SEL0 = 2'd0, A_SEL1 = 2'd1, A_CTR0 = 2'd2, A_CTR1 = 2'd3;
    localparam logic [9:0] V_BURST_S = 10'h001, V_BURST_O = 10'h008;
    localparam logic [9:0] V_MEM_S = 10'h002, V_MEM_O = 10'h010;
    localparam logic [9:0] V_ALL_S = 10'h004, V_ALL_O = 10'h020;
    localparam logic [9:0] V_RCV = 10'h040, V_BNR = 10'h080, V_HIT = 10'h100, V_HITM = 10'h200;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          wr_en = 1'b0;
    logic [AW-1:0] wr_addr = '0;
    logic [DW-1:0] wr_data = '0;
    logic [AW-1:0] rd_addr = '0;
    logic [DW-1:0] rd_data;
    logic [9:0]    bus_evt = '0;
    logic [1:0]    clk_ratio = 2'b00;
    logic [NC-1:0] ovf_pin;

    int n_run = 0;
    int n_fail = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    evt_ovf_monitor #(.NUM_CNT(NC), .CNT_W(CW)) dut_i (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
        .bus_evt(bus_evt), .clk_ratio(clk_ratio), .ovf_pin(ovf_pin)
    );

    task automatic check(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [DW-1:0] mk_sel(input logic [7:0] code, input logic [7:0] um, input logic pc);
        return (DW'(pc) << 19) | (DW'(um) << 8) | DW'(code);
    endfunction

    task automatic run(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(input logic [AW-1:0] a, input logic [DW-1:0] d);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [AW-1:0] a, output logic [DW-1:0] d);
        rd_addr = a;
        #0.5;
        d = rd_data;
    endtask

    task automatic t_reset();
        logic [DW-1:0] v;
        for (int a = 0; a < 4; a++) begin
            rd(AW'(a), v);
            check("R1 reg after reset", v, '0);
        end
        check("R1 pins after reset", DW'(ovf_pin), '0);
    endtask

    task automatic t_regs();
        logic [DW-1:0] v;
        wr(A_SEL0, '1);
        rd(A_SEL0, v); check("R2 select readback", v, 20'hFFFFF);
        wr(A_SEL0, '0);
        wr(A_CTR0, 20'hABCDE);
        rd(A_CTR0, v); check("R2 counter truncated readback", v, 20'h0BCDE);
        rd(A_CTR1, v); check("R11 other counter untouched", v, '0);
    endtask

    task automatic t_trans();
        logic [DW-1:0] v;
        wr(A_SEL0, mk_sel(8'h6E, 8'h00, 1'b0)); wr(A_CTR0, '0);
        bus_evt = V_BURST_S; run(3);
        bus_evt = V_BURST_O; run(2);
        bus_evt = '0;
        rd(A_CTR0, v); check("R3 burst self only", v, 20'd3);
        wr(A_SEL0, mk_sel(8'h6E, 8'h20, 1'b0)); wr(A_CTR0, '0);
        bus_evt = V_BURST_S; run(2);
        bus_evt = V_BURST_O; run(2);
        bus_evt = V_BURST_S | V_BURST_O; run(1);
        bus_evt = '0;
        rd(A_CTR0, v); check("R3 burst any agent", v, 20'd5);
        wr(A_SEL0, mk_sel(8'h6F, 8'h00, 1'b0)); wr(A_CTR0, '0);
        bus_evt = V_MEM_S | V_ALL_S; run(2);
        bus_evt = V_MEM_O; run(2);
        bus_evt = '0;
        rd(A_CTR0, v); check("R3 memory self", v, 20'd2);
        wr(A_SEL0, mk_sel(8'h70, 8'h20, 1'b0)); wr(A_CTR0, '0);
        bus_evt = V_ALL_S; run(1);
        bus_evt = V_ALL_O; run(1);
        bus_evt = V_BURST_S; run(1);
        bus_evt = '0;
        rd(A_CTR0, v); check("R3 any-kind any agent", v, 20'd2);
    endtask

    task automatic t_dur();
        logic [DW-1:0] v;
        wr(A_SEL0, mk_sel(8'h7B, 8'h00, 1'b0)); wr(A_CTR0, '0);
        bus_evt = V_HITM; run(4);
        bus_evt = V_HIT; run(2);
        bus_evt = '0;
        rd(A_CTR0, v); check("R4 modified-hit duration", v, 20'd4);
        wr(A_SEL0, mk_sel(8'h64, 8'h20, 1'b0)); wr(A_CTR0, '0);
        bus_evt = V_RCV; run(3);
        bus_evt = '0;
        rd(A_CTR0, v); check("R4 data receive with any mask", v, 20'd3);
    endtask

    task automatic t_bad();
        logic [DW-1:0] v;
        wr(A_SEL0, mk_sel(8'h55, 8'h00, 1'b0)); wr(A_CTR0, '0);
        bus_evt = '1; run(3);
        bus_evt = '0;
        rd(A_CTR0, v); check("R5 unknown code", v, '0);
        wr(A_SEL0, mk_sel(8'h6E, 8'h01, 1'b0));
        bus_evt = '1; run(3);
        bus_evt = '0;
        rd(A_CTR0, v); check("R5 unknown unit mask", v, '0);
    endtask

    task automatic t_prio();
        logic [DW-1:0] v;
        wr(A_SEL0, mk_sel(8'h7A, 8'h00, 1'b0)); wr(A_CTR0, '0);
        bus_evt = V_HIT;
        wr(A_CTR0, 20'd100);
        bus_evt = '0;
        rd(A_CTR0, v); check("R6 write beats increment", v, 20'd100);
        run(2);
        rd(A_CTR0, v); check("R6 hold without event", v, 20'd100);
    endtask

    task automatic t_pulse();
        logic [DW-1:0] v;
        clk_ratio = 2'b00;
        wr(A_SEL0, mk_sel(8'h61, 8'h00, 1'b1)); wr(A_CTR0, 20'h0FFFE);
        bus_evt = V_BNR; run(1);
        rd(A_CTR0, v); check("R7 reaches all ones", v, 20'h0FFFF);
        check("R8 pin low before wrap", DW'(ovf_pin[0]), '0);
        run(1);
        rd(A_CTR0, v); check("R7 wrap to zero", v, '0);
        check("R8 pulse high", DW'(ovf_pin[0]), 20'd1);
        check("R11 other pin quiet", DW'(ovf_pin[1]), '0);
        run(1);
        bus_evt = '0;
        rd(A_CTR0, v); check("R7 counts after wrap", v, 20'd1);
        check("R8 pulse one clock", DW'(ovf_pin[0]), '0);
        wr(A_CTR0, 20'h0FFFF);
        check("R7 write all ones no pin", DW'(ovf_pin[0]), '0);
        wr(A_CTR0, '0);
        check("R7 write zero no pin", DW'(ovf_pin[0]), '0);
    endtask

    task automatic t_toggle();
        clk_ratio = 2'b01;
        wr(A_SEL0, mk_sel(8'h61, 8'h00, 1'b0)); wr(A_CTR0, 20'h0FFFF);
        bus_evt = V_BNR; run(1);
        bus_evt = '0;
        check("R9 first overflow raises pin", DW'(ovf_pin[0]), 20'd1);
        run(2);
        check("R9 level held", DW'(ovf_pin[0]), 20'd1);
        wr(A_CTR0, 20'h0FFFF);
        bus_evt = V_BNR; run(1);
        bus_evt = '0;
        check("R9 second overflow lowers pin", DW'(ovf_pin[0]), '0);
        check("R11 other pin quiet", DW'(ovf_pin[1]), '0);
    endtask

    task automatic t_ratio();
        logic [DW-1:0] v;
        clk_ratio = 2'b10;
        wr(A_SEL0, mk_sel(8'h61, 8'h00, 1'b1)); wr(A_CTR0, 20'h0FFFF);
        bus_evt = V_BNR; run(1);
        bus_evt = '0;
        check("R10 no pulse at bad ratio", DW'(ovf_pin[0]), '0);
        rd(A_CTR0, v); check("R10 still counts", v, '0);
        clk_ratio = 2'b11;
        wr(A_SEL0, mk_sel(8'h61, 8'h00, 1'b0)); wr(A_CTR0, 20'h0FFFF);
        bus_evt = V_BNR; run(1);
        bus_evt = '0;
        check("R10 no toggle at bad ratio", DW'(ovf_pin[0]), '0);
        clk_ratio = 2'b00; #0.5;
        check("R10 state frozen during bad ratio", DW'(ovf_pin[0]), '0);
        wr(A_CTR0, 20'h0FFFF);
        bus_evt = V_BNR; run(1);
        bus_evt = '0;
        check("R9 toggle up at 2:1", DW'(ovf_pin[0]), 20'd1);
        clk_ratio = 2'b10; #0.5;
        check("R10 pin gated low", DW'(ovf_pin[0]), '0);
        clk_ratio = 2'b00; #0.5;
        check("R10 held level returns", DW'(ovf_pin[0]), 20'd1);
    endtask

    task automatic t_natural();
        logic [DW-1:0] v;
        clk_ratio = 2'b00;
        wr(A_SEL1, mk_sel(8'h64, 8'h00, 1'b0)); wr(A_CTR1, '0);
        bus_evt = V_RCV; run(65535);
        rd(A_CTR1, v); check("R7 natural count to all ones", v, 20'h0FFFF);
        check("R9 pin1 low before wrap", DW'(ovf_pin[1]), '0);
        run(1);
        bus_evt = '0;
        rd(A_CTR1, v); check("R7 natural wrap", v, '0);
        check("R9 pin1 toggled", DW'(ovf_pin[1]), 20'd1);
        rd(A_CTR0, v); check("R11 counter0 ignores other select", v, '0);
        check("R11 pin0 unchanged", DW'(ovf_pin[0]), 20'd1);
    endtask

    initial begin
        #(5.0 * 190000);
        if (!done) begin
            n_run++; n_fail++;
            $display("FAIL watchdog expired actual=running expected=done");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        run(3);
        rst_n = 1'b1;
        run(1);
        t_reset();
        t_regs();
        t_trans();
        t_dur();
        t_bad();
        t_prio();
        t_pulse();
        t_toggle();
        t_ratio();
        t_natural();
        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule